// File: doc/BRIEF.md
# Channel Logical Device Command Responder

This block answers the one-byte commands a host channel sends to a control unit that presents four logical devices, numbered 0, 1, 2 and 4. For each device it keeps a set of registers: a 32-bit address, a 16-bit start value and a 16-bit stop value. It also keeps a pending status byte, sense byte 0 and a busy flag. A command arrives as a single-cycle strobe carrying a code, a device number and a parity flag. Parameter bytes for the register-loading commands follow on a byte stream. Read-type commands answer on a response byte stream. Every command ends with exactly one ending status byte.

Moving data and the channel's electrical signalling are handled elsewhere. The register values are exported so that the data engine can use them. When the local processor finishes a started operation, it pulses a per-device done input. That pulse turns the withheld device-end into pending status and releases the busy condition.

Status bits are numbered from the most significant bit, so bit 0 is 0x80. The values used are: busy 0x10, channel end 0x08, device end 0x04, unit check 0x02. In sense byte 0, command reject is 0x80 and bus-out check is 0x20. Devices 0, 1, 2 and 4 map to slots 0, 1, 2 and 3. Slot k uses bits [32k+31:32k] of `addr_regs` and bits [16k+15:16k] of `start_regs` and `stop_regs`.

Top module: `chan_cmd_responder`

## Requirements
- R1: The codes 0x01 (write), 0x02 (read), 0x03 (no-op) and 0x0B (alarm) end with status 0x0C (channel end with device end) and produce no response bytes.
- R2: Code 0xE4 answers with the seven response bytes FF 32 58 00 32 51 FF, then status 0x0C.
- R3: Code 0x0E answers with three 0x00 bytes, and code 0x12 answers with four 0x00 bytes. Each then ends with status 0x0C.
- R4: Code 0x04 answers with four bytes: sense byte 0 of the device, then three 0x00 bytes. It ends with status 0x0C and clears sense byte 0. It is accepted while the device is busy.
- R5: A code outside the set {00,01,02,03,04,07,0B,0E,12,1B,27,E4} ends with status 0x0E and sets command reject (0x80) in sense byte 0.
- R6: A parity error on the command, or on any parameter byte, ends with status 0x0E and sets bus-out check (0x20) in sense byte 0. No register changes.
- R7: Device numbers 3, 5, 6 and 7 end with status 0x0E and change no state.
- R8: Code 0x1B loads the address register from exactly four parameter bytes, most significant byte first. Any other count ends with status 0x0E and command reject, and the register keeps its old value.
- R9: On device 0, an address of 0x0001E000 or above (including every 0xFFFFxxxx value) is rejected with status 0x0E and command reject. The other devices accept 0xFFFFxxxx.
- R10: Codes 0x07 (stop) and 0x27 (start) load their register from exactly two bytes, most significant byte first. A count other than two is rejected with status 0x0E and command reject, and the old value is kept.
- R11: An accepted start ends with 0x0C on device 0. On any other device it ends with 0x08 and the device turns busy, with pending status 0x10. While busy, every code except 0x00 and 0x04 ends with 0x10 and has no effect. A done pulse clears busy and makes the pending status 0x04.
- R12: Code 0x00 returns the pending status byte as its ending status (0x00 when nothing is pending). It then clears the pending status, except for the busy bit.
- R13: Response bytes come one per cycle, with the last one flagged. Status follows one cycle after the last response byte or the last parameter byte, or one cycle after the strobe when neither is present. Exactly one status cycle occurs per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while no command is in progress |
| cmd_code | input | 8 | Command code |
| cmd_dev | input | 3 | Logical device number |
| cmd_perr | input | 1 | Parity error seen on the command byte |
| prm_valid | input | 1 | Parameter byte valid |
| prm_byte | input | 8 | Parameter byte |
| prm_last | input | 1 | Final parameter byte of the command |
| prm_perr | input | 1 | Parity error on this parameter byte |
| dev_done | input | 4 | Per-slot processing-done pulse |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Response byte |
| rsp_last | output | 1 | Final response byte |
| stat_valid | output | 1 | Ending status valid |
| stat_byte | output | 8 | Ending status byte |
| addr_regs | output | 128 | Address registers, four slots |
| start_regs | output | 64 | Start registers, four slots |
| stop_regs | output | 64 | Stop registers, four slots |

## Verification
The hardest situation to reach is the busy window of a non-zero device. During that window the same commands behave differently: Test I/O must report 0x10 and leave it in place, Sense must still be served, and a register load must be refused without its parameter bytes being consumed. The bench therefore issues a start on device 1 and holds back the done pulse. It runs no-op, Test I/O, Sense and Set Address against the busy slot, then fires the done pulse and reads pending status twice to see device-end and then zero. The address limit on device 0 is probed on both sides of the boundary, at 0x0001DFFF and 0x0001E000.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int N_SLOT = 4;
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam int ADDR_W = 32;
  localparam int REG_W  = 16;
  localparam int LEN_W  = 3;

  localparam logic [7:0] OP_TIO   = 8'h00;
  localparam logic [7:0] OP_WR    = 8'h01;
  localparam logic [7:0] OP_RD    = 8'h02;
  localparam logic [7:0] OP_NOP   = 8'h03;
  localparam logic [7:0] OP_SNS   = 8'h04;
  localparam logic [7:0] OP_STOP  = 8'h07;
  localparam logic [7:0] OP_ALRM  = 8'h0B;
  localparam logic [7:0] OP_MAN   = 8'h0E;
  localparam logic [7:0] OP_XY    = 8'h12;
  localparam logic [7:0] OP_ADDR  = 8'h1B;
  localparam logic [7:0] OP_START = 8'h27;
  localparam logic [7:0] OP_SID   = 8'hE4;

  localparam logic [7:0] ST_BUSY = 8'h10;
  localparam logic [7:0] ST_CE   = 8'h08;
  localparam logic [7:0] ST_DE   = 8'h04;
  localparam logic [7:0] ST_UC   = 8'h02;
  localparam logic [7:0] SN_REJ  = 8'h80;
  localparam logic [7:0] SN_BOC  = 8'h20;

  localparam logic [ADDR_W-1:0] DEV0_LIMIT = 32'h0001_E000;

  typedef enum logic [1:0] {PH_IDLE, PH_PARM, PH_RESP, PH_STAT} phase_t;
  typedef enum logic [2:0] {G_OK, G_NODEV, G_PERR, G_BAD, G_BUSY} gate_t;

  typedef struct packed {
    logic              ok;
    logic [SLOT_W-1:0] idx;
  } slot_t;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
    logic              wr_addr;
    logic              wr_start;
    logic              wr_stop;
    logic              set_busy;
    logic              pend_wr;
    logic [7:0]        pend_val;
    logic [7:0]        sense_or;
    logic              sense_clr;
    logic [ADDR_W-1:0] val;
  } commit_t;

  function automatic slot_t slot_of(input logic [2:0] dev);
    slot_t s;
    s.ok = 1'b1;
    case (dev)
      3'd0: s.idx = SLOT_W'(0);
      3'd1: s.idx = SLOT_W'(1);
      3'd2: s.idx = SLOT_W'(2);
      3'd4: s.idx = SLOT_W'(3);
      default: begin s.ok = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction

  function automatic logic known_op(input logic [7:0] c);
    case (c)
      OP_TIO, OP_WR, OP_RD, OP_NOP, OP_SNS, OP_STOP, OP_ALRM,
      OP_MAN, OP_XY, OP_ADDR, OP_START, OP_SID: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] parm_len(input logic [7:0] c);
    case (c)
      OP_ADDR:          return LEN_W'(4);
      OP_STOP, OP_START: return LEN_W'(2);
      default:          return '0;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] resp_len(input logic [7:0] c);
    case (c)
      OP_SNS:  return LEN_W'(4);
      OP_SID:  return LEN_W'(7);
      OP_MAN:  return LEN_W'(3);
      OP_XY:   return LEN_W'(4);
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] sid_byte(input logic [LEN_W-1:0] i);
    case (i)
      3'd0: return 8'hFF;
      3'd1: return 8'h32;
      3'd2: return 8'h58;
      3'd3: return 8'h00;
      3'd4: return 8'h32;
      3'd5: return 8'h51;
      3'd6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic dev0_addr_ok(input logic [ADDR_W-1:0] a);
    return a < DEV0_LIMIT;
  endfunction
endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [2:0]        cmd_dev,
  input  logic              cmd_perr,
  input  logic              prm_valid,
  input  logic [7:0]        prm_byte,
  input  logic              prm_last,
  input  logic              prm_perr,
  input  logic [N_SLOT-1:0] busy_vec,
  input  logic [7:0]        pend_sel,
  input  logic [7:0]        sense_sel,
  output logic [SLOT_W-1:0] cur_slot,
  output commit_t           cm,
  output logic              rsp_valid,
  output logic [7:0]        rsp_byte,
  output logic              rsp_last,
  output logic              stat_valid,
  output logic [7:0]        stat_byte
);
  phase_t            phase_q;
  gate_t             gate_q;
  logic [7:0]        code_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] shift_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  idx_q;
  logic              dperr_q;

  slot_t       in_slot;
  gate_t       in_gate;
  logic        in_free;
  logic [LEN_W-1:0] rlen;

  assign in_slot  = slot_of(cmd_dev);
  assign in_free  = (cmd_code == OP_TIO) || (cmd_code == OP_SNS);
  assign rlen     = resp_len(code_q);
  assign cur_slot = slot_q;

  always_comb begin
    if (!in_slot.ok)                             in_gate = G_NODEV;
    else if (cmd_perr)                           in_gate = G_PERR;
    else if (!known_op(cmd_code))                in_gate = G_BAD;
    else if (busy_vec[in_slot.idx] && !in_free)  in_gate = G_BUSY;
    else                                         in_gate = G_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      gate_q  <= G_OK;
      code_q  <= '0;
      slot_q  <= '0;
      shift_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      dperr_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (cmd_valid) begin
          code_q  <= cmd_code;
          slot_q  <= in_slot.idx;
          gate_q  <= in_gate;
          shift_q <= '0;
          cnt_q   <= '0;
          idx_q   <= '0;
          dperr_q <= 1'b0;
          if (in_gate != G_OK)                 phase_q <= PH_STAT;
          else if (parm_len(cmd_code) != '0)   phase_q <= PH_PARM;
          else if (resp_len(cmd_code) != '0)   phase_q <= PH_RESP;
          else                                 phase_q <= PH_STAT;
        end
        PH_PARM: if (prm_valid) begin
          shift_q <= {shift_q[ADDR_W-9:0], prm_byte};
          if (cnt_q != {LEN_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
          dperr_q <= dperr_q | prm_perr;
          if (prm_last) phase_q <= PH_STAT;
        end
        PH_RESP: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == rlen - 1'b1) phase_q <= PH_STAT;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // response byte source
  always_comb begin
    rsp_valid = (phase_q == PH_RESP);
    rsp_last  = rsp_valid && (idx_q == rlen - 1'b1);
    rsp_byte  = 8'h00;
    if (rsp_valid) begin
      if (code_q == OP_SNS)      rsp_byte = (idx_q == '0) ? sense_sel : 8'h00;
      else if (code_q == OP_SID) rsp_byte = sid_byte(idx_q);
    end
  end

  // ending status and the state update it carries
  always_comb begin
    cm         = '0;
    cm.slot    = slot_q;
    stat_valid = (phase_q == PH_STAT);
    stat_byte  = 8'h00;
    if (stat_valid) begin
      case (gate_q)
        G_NODEV: stat_byte = ST_CE | ST_DE | ST_UC;
        G_PERR: begin
          stat_byte = ST_CE | ST_DE | ST_UC; cm.en = 1'b1; cm.sense_or = SN_BOC;
        end
        G_BAD: begin
          stat_byte = ST_CE | ST_DE | ST_UC; cm.en = 1'b1; cm.sense_or = SN_REJ;
        end
        G_BUSY: stat_byte = ST_BUSY;
        default: begin
          case (code_q)
            OP_TIO: begin
              stat_byte   = pend_sel;
              cm.en       = 1'b1;
              cm.pend_wr  = 1'b1;
              cm.pend_val = pend_sel & ST_BUSY;
            end
            OP_SNS: begin
              stat_byte    = ST_CE | ST_DE;
              cm.en        = 1'b1;
              cm.sense_clr = 1'b1;
            end
            OP_ADDR, OP_STOP, OP_START: begin
              cm.en = 1'b1;
              if (dperr_q) begin
                stat_byte = ST_CE | ST_DE | ST_UC; cm.sense_or = SN_BOC;
              end else if (cnt_q != parm_len(code_q) ||
                           (code_q == OP_ADDR && slot_q == '0 && !dev0_addr_ok(shift_q))) begin
                stat_byte = ST_CE | ST_DE | ST_UC; cm.sense_or = SN_REJ;
              end else begin
                stat_byte = ST_CE | ST_DE;
                cm.val    = shift_q;
                case (code_q)
                  OP_ADDR: cm.wr_addr = 1'b1;
                  OP_STOP: cm.wr_stop = 1'b1;
                  default: begin
                    cm.wr_start = 1'b1;
                    if (slot_q != '0) begin
                      stat_byte   = ST_CE;
                      cm.set_busy = 1'b1;
                      cm.pend_wr  = 1'b1;
                      cm.pend_val = ST_BUSY;
                    end
                  end
                endcase
              end
            end
            default: stat_byte = ST_CE | ST_DE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  commit_t                     cm,
  input  logic [N_SLOT-1:0]           dev_done,
  output logic [N_SLOT-1:0]           busy_vec,
  output logic [N_SLOT-1:0]           done_evt,
  output logic [N_SLOT-1:0][7:0]      pend_arr,
  output logic [N_SLOT-1:0][7:0]      sense_arr,
  output logic [N_SLOT*ADDR_W-1:0]    addr_regs,
  output logic [N_SLOT*REG_W-1:0]     start_regs,
  output logic [N_SLOT*REG_W-1:0]     stop_regs
);
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  start_q, stop_q;
    logic [7:0]        pend_q, sense_q, pend_n, sense_n;
    logic              busy_q, busy_n, hit;

    assign hit         = cm.en && (cm.slot == SLOT_W'(i));
    assign done_evt[i] = dev_done[i] && busy_q;

    always_comb begin
      pend_n  = pend_q;
      busy_n  = busy_q;
      sense_n = sense_q;
      if (hit && cm.pend_wr)   pend_n = cm.pend_val;
      if (hit && cm.set_busy)  busy_n = 1'b1;
      if (done_evt[i]) begin
        busy_n = 1'b0;
        pend_n = (pend_n & ~ST_BUSY) | ST_DE;
      end
      if (hit && cm.sense_clr) sense_n = 8'h00;
      if (hit)                 sense_n = sense_n | cm.sense_or;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q <= '0; start_q <= '0; stop_q <= '0;
        pend_q <= '0; sense_q <= '0; busy_q <= 1'b0;
      end else begin
        pend_q  <= pend_n;
        busy_q  <= busy_n;
        sense_q <= sense_n;
        if (hit && cm.wr_addr)  addr_q  <= cm.val;
        if (hit && cm.wr_start) start_q <= cm.val[REG_W-1:0];
        if (hit && cm.wr_stop)  stop_q  <= cm.val[REG_W-1:0];
      end
    end

    assign busy_vec[i]                    = busy_q;
    assign pend_arr[i]                    = pend_q;
    assign sense_arr[i]                   = sense_q;
    assign addr_regs[i*ADDR_W +: ADDR_W]  = addr_q;
    assign start_regs[i*REG_W +: REG_W]   = start_q;
    assign stop_regs[i*REG_W +: REG_W]    = stop_q;
  end
endmodule

// File: rtl/chan_cmd_responder.sv
module chan_cmd_responder
  import ccr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [7:0]               cmd_code,
  input  logic [2:0]               cmd_dev,
  input  logic                     cmd_perr,
  input  logic                     prm_valid,
  input  logic [7:0]               prm_byte,
  input  logic                     prm_last,
  input  logic                     prm_perr,
  input  logic [N_SLOT-1:0]        dev_done,
  output logic                     rsp_valid,
  output logic [7:0]               rsp_byte,
  output logic                     rsp_last,
  output logic                     stat_valid,
  output logic [7:0]               stat_byte,
  output logic [N_SLOT*ADDR_W-1:0] addr_regs,
  output logic [N_SLOT*REG_W-1:0]  start_regs,
  output logic [N_SLOT*REG_W-1:0]  stop_regs
);
  commit_t                cm;
  logic [SLOT_W-1:0]      cur_slot;
  logic [N_SLOT-1:0]      busy_vec;
  logic [N_SLOT-1:0]      done_evt;
  logic [N_SLOT-1:0][7:0] pend_arr;
  logic [N_SLOT-1:0][7:0] sense_arr;

  ccr_ctrl u_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_code, .cmd_dev, .cmd_perr,
    .prm_valid, .prm_byte, .prm_last, .prm_perr,
    .busy_vec,
    .pend_sel  (pend_arr[cur_slot]),
    .sense_sel (sense_arr[cur_slot]),
    .cur_slot, .cm,
    .rsp_valid, .rsp_byte, .rsp_last, .stat_valid, .stat_byte
  );

  ccr_regfile u_regs (
    .clk, .rst_n, .cm, .dev_done,
    .busy_vec, .done_evt, .pend_arr, .sense_arr,
    .addr_regs, .start_regs, .stop_regs
  );
endmodule

// File: rtl/ccr_checks.sv
module ccr_checks
  import ccr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic              stat_valid,
  input logic [7:0]        stat_byte,
  input logic [N_SLOT-1:0] busy_vec,
  input logic [N_SLOT-1:0] done_evt,
  input logic [N_SLOT-1:0] dev_done
);
  // R5 R6 R7: unit check always travels with channel end and device end
  assert_uc_has_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_byte[1] |-> stat_byte[3:2] == 2'b11);

  assert_one_status_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  assert_rsp_then_status_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_last |=> stat_valid);

  assert_streams_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, stat_valid}));

  assert_ce_only_sets_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_byte == ST_CE |=> |busy_vec);

  for (genvar i = 0; i < N_SLOT; i++) begin : g_rel
    assert_busy_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_vec[i]) |-> $past(dev_done[i]) && $past(done_evt[i]));
  end
endmodule

bind chan_cmd_responder ccr_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .rsp_valid  (rsp_valid),
  .rsp_last   (rsp_last),
  .stat_valid (stat_valid),
  .stat_byte  (stat_byte),
  .busy_vec   (busy_vec),
  .done_evt   (done_evt),
  .dev_done   (dev_done)
);

// File: tb/test_chan_cmd_responder.sv
module test_chan_cmd_responder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_perr = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [2:0]  cmd_dev = '0;
  logic        prm_valid = 1'b0, prm_last = 1'b0, prm_perr = 1'b0;
  logic [7:0]  prm_byte = '0;
  logic [3:0]  dev_done = '0;
  logic        rsp_valid, rsp_last, stat_valid;
  logic [7:0]  rsp_byte, stat_byte;
  logic [127:0] addr_regs;
  logic [63:0]  start_regs, stop_regs;

  int errors = 0;
  int checks = 0;
  bit in_cmd = 0;

  // reference model state
  logic [31:0] m_addr[4];
  logic [15:0] m_start[4], m_stop[4];
  logic [7:0]  m_pend[4], m_sense[4];
  bit          m_busy[4];
  logic [7:0]  ebuf[8];

  chan_cmd_responder i_chan_cmd_responder (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog R13 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // idle-cycle comparison on every clock
  always @(negedge clk) if (rst_n && !in_cmd) begin
    chk("R13 idle stream quiet", {rsp_valid, stat_valid}, 0);
  end

  function automatic int slot_num(input logic [2:0] d);
    case (d) 3'd0: return 0; 3'd1: return 1; 3'd2: return 2; 3'd4: return 3; default: return -1; endcase
  endfunction

  task automatic model_exec(input logic [7:0] code, input logic [2:0] dev, input bit cperr,
                            input int n, input logic [31:0] data, input bit dperr,
                            output bit send_p, output logic [7:0] est, output int elen);
    int s = slot_num(dev);
    bit known = (code inside {8'h00,8'h01,8'h02,8'h03,8'h04,8'h07,8'h0B,8'h0E,8'h12,8'h1B,8'h27,8'hE4});
    int need = (code == 8'h1B) ? 4 : (code == 8'h07 || code == 8'h27) ? 2 : 0;
    send_p = 0; elen = 0; est = 8'h0C;
    if (s < 0) begin est = 8'h0E; return; end
    if (cperr) begin m_sense[s] |= 8'h20; est = 8'h0E; return; end
    if (!known) begin m_sense[s] |= 8'h80; est = 8'h0E; return; end
    if (m_busy[s] && code != 8'h00 && code != 8'h04) begin est = 8'h10; return; end
    send_p = (need > 0);
    case (code)
      8'h00: begin est = m_pend[s]; m_pend[s] &= 8'h10; end
      8'h04: begin ebuf[0] = m_sense[s]; ebuf[1] = 0; ebuf[2] = 0; ebuf[3] = 0; elen = 4; m_sense[s] = 0; end
      8'hE4: begin
        ebuf[0] = 8'hFF; ebuf[1] = 8'h32; ebuf[2] = 8'h58; ebuf[3] = 8'h00;
        ebuf[4] = 8'h32; ebuf[5] = 8'h51; ebuf[6] = 8'hFF; elen = 7;
      end
      8'h0E: begin for (int k = 0; k < 3; k++) ebuf[k] = 0; elen = 3; end
      8'h12: begin for (int k = 0; k < 4; k++) ebuf[k] = 0; elen = 4; end
      8'h1B, 8'h07, 8'h27: begin
        if (dperr) begin m_sense[s] |= 8'h20; est = 8'h0E; end
        else if (n != need || (code == 8'h1B && s == 0 && data >= 32'h1E000)) begin
          m_sense[s] |= 8'h80; est = 8'h0E;
        end else if (code == 8'h1B) m_addr[s] = data;
        else if (code == 8'h07) m_stop[s] = data[15:0];
        else begin
          m_start[s] = data[15:0];
          if (s != 0) begin est = 8'h08; m_busy[s] = 1; m_pend[s] = 8'h10; end
        end
      end
      default: est = 8'h0C;
    endcase
  endtask

  task automatic check_regs(input string tag);
    bit ok = 1;
    for (int i = 0; i < 4; i++) begin
      if (addr_regs[32*i +: 32] !== m_addr[i]) ok = 0;
      if (start_regs[16*i +: 16] !== m_start[i]) ok = 0;
      if (stop_regs[16*i +: 16] !== m_stop[i]) ok = 0;
    end
    chk({tag, " registers"}, ok, 1);
  endtask

  task automatic run(input string tag, input logic [7:0] code, input logic [2:0] dev,
                     input bit cperr, input int n, input logic [31:0] data, input bit dperr);
    bit send_p; logic [7:0] est; int elen; int got = 0; bit seen = 0;
    model_exec(code, dev, cperr, n, data, dperr, send_p, est, elen);
    @(negedge clk);
    in_cmd = 1;
    cmd_valid = 1; cmd_code = code; cmd_dev = dev; cmd_perr = cperr;
    @(negedge clk);
    cmd_valid = 0; cmd_perr = 0;
    if (send_p) begin
      for (int k = 0; k < n; k++) begin
        prm_valid = 1; prm_byte = data[8*(n-1-k) +: 8];
        prm_last = (k == n-1); prm_perr = dperr && (k == n-1);
        @(negedge clk);
      end
      prm_valid = 0; prm_last = 0; prm_perr = 0;
    end
    for (int t = 0; t < 12 && !seen; t++) begin
      if (rsp_valid) begin
        if (got < elen) chk({tag, " response byte"}, rsp_byte, ebuf[got]);
        chk({tag, " R13 last flag"}, rsp_last, (got == elen-1));
        got++;
      end
      if (stat_valid) begin
        chk({tag, " status"}, stat_byte, est);
        seen = 1;
      end else @(negedge clk);
    end
    chk({tag, " R13 status seen"}, seen, 1);
    chk({tag, " response count"}, got, elen);
    @(negedge clk);
    in_cmd = 0;
    check_regs(tag);
  endtask

  task automatic pulse_done(input int s);
    @(negedge clk);
    dev_done[s] = 1'b1;
    @(negedge clk);
    dev_done = '0;
    if (m_busy[s]) begin m_busy[s] = 0; m_pend[s] = (m_pend[s] & ~8'h10) | 8'h04; end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = 0; m_start[i] = 0; m_stop[i] = 0; m_pend[i] = 0; m_sense[i] = 0; m_busy[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R13 outputs", {rsp_valid, stat_valid}, 0);
    check_regs("reset");

    run("R1 nop dev0",   8'h03, 3'd0, 0, 0, 0, 0);
    run("R1 write dev1", 8'h01, 3'd1, 0, 0, 0, 0);
    run("R1 read dev2",  8'h02, 3'd2, 0, 0, 0, 0);
    run("R1 alarm dev4", 8'h0B, 3'd4, 0, 0, 0, 0);
    run("R2 sense id",   8'hE4, 3'd0, 0, 0, 0, 0);
    run("R3 manual",     8'h0E, 3'd1, 0, 0, 0, 0);
    run("R3 xy",         8'h12, 3'd4, 0, 0, 0, 0);
    run("R4 sense clean",8'h04, 3'd0, 0, 0, 0, 0);
    run("R5 bad code",   8'h55, 3'd1, 0, 0, 0, 0);
    run("R4 R5 sense",   8'h04, 3'd1, 0, 0, 0, 0);
    run("R4 sense clear",8'h04, 3'd1, 0, 0, 0, 0);
    run("R6 cmd parity", 8'h03, 3'd2, 1, 0, 0, 0);
    run("R6 sense",      8'h04, 3'd2, 0, 0, 0, 0);
    run("R7 dev3",       8'h03, 3'd3, 0, 0, 0, 0);
    run("R7 dev7 addr",  8'h1B, 3'd7, 0, 0, 0, 0);
    run("R8 addr dev1",  8'h1B, 3'd1, 0, 4, 32'h12345678, 0);
    run("R8 short addr", 8'h1B, 3'd1, 0, 3, 32'h00ABCDEF, 0);
    run("R9 dev0 top ok",8'h1B, 3'd0, 0, 4, 32'h0001DFFF, 0);
    run("R9 dev0 limit", 8'h1B, 3'd0, 0, 4, 32'h0001E000, 0);
    run("R9 dev0 ctl",   8'h1B, 3'd0, 0, 4, 32'hFFFF0010, 0);
    run("R9 dev2 ctl",   8'h1B, 3'd2, 0, 4, 32'hFFFF1234, 0);
    run("R6 data parity",8'h1B, 3'd2, 0, 4, 32'h00000055, 1);
    run("R10 stop dev4", 8'h07, 3'd4, 0, 2, 32'h0000ABCD, 0);
    run("R10 short stop",8'h07, 3'd4, 0, 1, 32'h00000011, 0);
    run("R10 long stop", 8'h07, 3'd4, 0, 3, 32'h00112233, 0);
    run("R12 tio empty", 8'h00, 3'd0, 0, 0, 0, 0);
    run("R11 start dev0",8'h27, 3'd0, 0, 2, 32'h00000010, 0);
    run("R11 start dev1",8'h27, 3'd1, 0, 2, 32'h00000020, 0);
    run("R11 busy nop",  8'h03, 3'd1, 0, 0, 0, 0);
    run("R11 busy addr", 8'h1B, 3'd1, 0, 4, 32'h99999999, 0);
    run("R12 tio busy",  8'h00, 3'd1, 0, 0, 0, 0);
    run("R12 tio busy 2",8'h00, 3'd1, 0, 0, 0, 0);
    run("R4 busy sense", 8'h04, 3'd1, 0, 0, 0, 0);
    run("R11 other dev", 8'h03, 3'd2, 0, 0, 0, 0);
    pulse_done(1);
    run("R11 R12 tio de",8'h00, 3'd1, 0, 0, 0, 0);
    run("R12 tio clear", 8'h00, 3'd1, 0, 0, 0, 0);
    run("R11 after done",8'h1B, 3'd1, 0, 4, 32'hCAFE0001, 0);
    run("R11 start dev4",8'h27, 3'd4, 0, 2, 32'h00007777, 0);
    pulse_done(3);
    run("R11 dev4 de",   8'h00, 3'd4, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule